// File: doc/BRIEF.md
# Audio Master Clock and Frame Generator

This block derives three audio timing signals from a single audio source clock: a master clock for an external converter, a bit clock, and a frame (word-select) clock. All outputs are levels or one-cycle strobes in the source-clock domain, so downstream serializers can use them as clock enables. Two 6-bit ratio fields set the timing. The divide field `div_i` makes the master clock period `div_i+1` source cycles. The frame-ratio field `fsr_i` makes the frame period `32*(fsr_i+1)` source cycles. The master clock therefore runs at `32*(fsr_i+1)/(div_i+1)` times the frame rate. Each frame carries two 32-bit slots, so it holds 64 bit-clock periods.

A role input picks between generating the clocks (master) and forwarding externally supplied bit and frame clocks (slave). A drive input chooses whether the generated master clock reaches its output pin. Software programs the fields first and then issues a clock-on command. The fields, the drive choice and the on/off state take effect only at frame boundaries, so a frame is never cut short. The ratio fields are captured when the generator starts and cleared once it has stopped.

Top module: `aclk_gen`

## Requirements
- R1: While reset is asserted, and after it is released until a clock-on command, every output (mck_o, mck_tick_o, bck_o, ws_o, frame_tick_o) is low.
- R2: With the drive bit captured as 1, mck_o repeats with a period of div_i+1 source cycles. It is high for the first ceil((div_i+1)/2) cycles of each period, and mck_tick_o pulses in that first cycle. The first period begins in the first cycle of the first frame.
- R3: With the drive bit captured as 0, mck_o and mck_tick_o stay low while the bit and frame clocks keep running.
- R4: The frame period is 32*(N) source cycles, where N is fsr_i+1 as captured. ws_o is low for the first half of the frame and high for the second half. frame_tick_o pulses in the first cycle of each frame.
- R5: At offset p (0-based) within a frame, bck_o equals bit 0 of floor(4*p/N). This gives 64 bit-clock periods per frame, each low in its first half.
- R6: A frame holds (32*N)/(div_i+1) master-clock periods. With div=7 and fsr=63 there are 256 mck_tick_o pulses per frame; with div=7 and fsr=15 there are 64.
- R7: In master role, a clock-on command (ck_on_i high without ck_off_i) while stopped starts the first frame in the next cycle. That same command captures div_i, fsr_i and mck_drive_i. Later changes to these inputs have no effect until the next start.
- R8: A clock-off command while running lets the current frame finish, and all outputs fall in the cycle after that frame's last cycle. A clock-on command before that boundary cancels the pending stop. When clock-on and clock-off arrive in the same cycle, the command is treated as off, including while stopped.
- R9: An fsr_i value below 3 is captured as 3, giving a frame of 128 source cycles.
- R10: With master_i low, the generator is stopped immediately and clock-on commands are ignored. mck_o, mck_tick_o and frame_tick_o stay low. bck_o and ws_o follow ext_bck_i and ext_ws_i delayed by SYNC_STAGES (default 2) source-clock registers.
- R11: With div_i equal to 0 and the drive bit set, mck_o stays high and mck_tick_o pulses in every cycle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Audio source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate clocks, 0: forward external clocks |
| mck_drive_i | input | 1 | 1: generated master clock reaches mck_o |
| div_i | input | DIV_W | Master clock divide field (period = value+1) |
| fsr_i | input | FS_W | Frame ratio field (frame = 32*(value+1) cycles) |
| ck_on_i | input | 1 | Clock-on command, one-cycle pulse |
| ck_off_i | input | 1 | Clock-off command, one-cycle pulse |
| ext_bck_i | input | 1 | External bit clock used in slave role |
| ext_ws_i | input | 1 | External frame clock used in slave role |
| mck_o | output | 1 | Master clock level |
| mck_tick_o | output | 1 | Strobe at the start of each master clock period |
| bck_o | output | 1 | Bit clock level |
| ws_o | output | 1 | Frame clock level |
| frame_tick_o | output | 1 | Strobe in the first cycle of each frame |

## Verification
A corrupted frame position or fractional bit accumulator shows first at bck_o, within a few source cycles: a bit edge comes early or late against floor(4*p/N). It shows at ws_o and frame_tick_o no later than the next half-frame. A wrong master-clock counter or captured high length shows at mck_o within one master period. A fault in the start or stop sequencing shows as a frame that opens a cycle early or late, or that ends mid-frame. The bench compares every output against its reference in every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

   // run sequencing of the generator
   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_RUN   = 2'd1,
      RS_DRAIN = 2'd2
   } run_state_e;

   // half-bit steps advanced per source cycle for a given slot count
   function automatic int unsigned half_bit_step(input int unsigned slots);
      return 2 * slots;
   endfunction

endpackage

// File: rtl/aclk_run_ctrl.sv
module aclk_run_ctrl
   import aclk_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic master_i,
   input  logic on_i,
   input  logic off_i,
   input  logic frame_last_i,
   output logic run_o,
   output logic load_o
);

   run_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      if (!master_i) begin
         state_d = RS_IDLE;
      end else begin
         unique case (state_q)
            RS_IDLE: begin
               if (on_i && !off_i) begin
                  state_d = RS_RUN;
                  load_o  = 1'b1;
               end
            end
            RS_RUN: begin
               if (off_i) state_d = frame_last_i ? RS_IDLE : RS_DRAIN;
            end
            RS_DRAIN: begin
               if (on_i && !off_i) state_d = RS_RUN;
               else if (frame_last_i) state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= RS_IDLE;
      else         state_q <= state_d;
   end

   assign run_o = (state_q != RS_IDLE);

endmodule

// File: rtl/aclk_mck_div.sv
module aclk_mck_div #(
   parameter int unsigned DIV_W         = 6,
   parameter bit          ODD_HIGH_LONG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             lvl_o,
   output logic             tick_o
);

   localparam int unsigned HI_W = DIV_W + 1;

   logic [DIV_W-1:0] top_q, cnt_q;
   logic [HI_W-1:0]  hi_q, hi_d;

   // length of the high phase; the variant picks which phase takes the odd cycle
   generate
      if (ODD_HIGH_LONG) begin : g_hi_ceil
         assign hi_d = ({1'b0, div_i} + HI_W'(2)) >> 1;
      end else begin : g_hi_floor
         assign hi_d = ({1'b0, div_i} + HI_W'(1)) >> 1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         top_q <= '0;
         hi_q  <= '0;
      end else if (load_i) begin
         top_q <= div_i;
         hi_q  <= hi_d;
      end else if (!run_i) begin
         top_q <= '0;
         hi_q  <= '0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (load_i || !run_i)  cnt_q <= '0;
      else if (cnt_q == top_q)    cnt_q <= '0;
      else                        cnt_q <= cnt_q + DIV_W'(1);
   end

   assign lvl_o  = run_i && ({1'b0, cnt_q} < hi_q);
   assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer
   import aclk_pkg::*;
#(
   parameter int unsigned FS_W   = 6,
   parameter int unsigned SLOT_W = 32,
   parameter int unsigned SLOTS  = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            run_i,
   input  logic            load_i,
   input  logic [FS_W-1:0] fsr_i,
   output logic            bck_o,
   output logic            ws_o,
   output logic            tick_o,
   output logic            last_o
);

   localparam int unsigned STEP   = half_bit_step(SLOTS);
   localparam int unsigned FS_MIN = STEP - 1;
   localparam int unsigned N_W    = FS_W + 1;
   localparam int unsigned POS_W  = $clog2(SLOT_W * (2 ** FS_W));
   localparam int unsigned HB_W   = $clog2(2 * SLOT_W * SLOTS);

   logic [FS_W-1:0]  fs_eff;
   logic [N_W-1:0]   n_d, n_q;
   logic [POS_W-1:0] last_d, half_d, last_q, half_q, pos_q;
   logic [N_W-1:0]   acc_q;
   logic [N_W:0]     acc_sum;
   logic [HB_W-1:0]  hb_q;
   logic             at_last;

   // a small ratio would need several half-bit steps per cycle: raise it
   assign fs_eff = (fsr_i < FS_W'(FS_MIN)) ? FS_W'(FS_MIN) : fsr_i;
   assign n_d    = {1'b0, fs_eff} + N_W'(1);
   assign last_d = POS_W'(SLOT_W) * POS_W'(n_d) - POS_W'(1);
   assign half_d = POS_W'(SLOT_W / 2) * POS_W'(n_d);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         n_q    <= '0;
         last_q <= '0;
         half_q <= '0;
      end else if (load_i) begin
         n_q    <= n_d;
         last_q <= last_d;
         half_q <= half_d;
      end else if (!run_i) begin
         n_q    <= '0;
         last_q <= '0;
         half_q <= '0;
      end
   end

   assign at_last = (pos_q == last_q);
   assign acc_sum = {1'b0, acc_q} + (N_W + 1)'(STEP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
         acc_q <= '0;
         hb_q  <= '0;
      end else if (load_i || !run_i || at_last) begin
         pos_q <= '0;
         acc_q <= '0;
         hb_q  <= '0;
      end else begin
         pos_q <= pos_q + POS_W'(1);
         if (acc_sum >= {1'b0, n_q}) begin
            acc_q <= N_W'(acc_sum - {1'b0, n_q});
            hb_q  <= hb_q + HB_W'(1);
         end else begin
            acc_q <= N_W'(acc_sum);
         end
      end
   end

   assign bck_o  = run_i && hb_q[0];
   assign ws_o   = run_i && (pos_q >= half_q);
   assign tick_o = run_i && (pos_q == '0);
   assign last_o = run_i && at_last;

endmodule

// File: rtl/aclk_slave_sync.sv
module aclk_slave_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bck_i,
   input  logic ws_i,
   output logic bck_o,
   output logic ws_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign bck_o = bck_i;
         assign ws_o  = ws_i;
      end else begin : g_chain
         logic [1:0] stage_q [STAGES];
         for (genvar g = 0; g < STAGES; g++) begin : g_st
            if (g == 0) begin : g_first
               always_ff @(posedge clk_i or negedge rst_ni) begin
                  if (!rst_ni) stage_q[0] <= 2'b00;
                  else         stage_q[0] <= {ws_i, bck_i};
               end
            end else begin : g_next
               always_ff @(posedge clk_i or negedge rst_ni) begin
                  if (!rst_ni) stage_q[g] <= 2'b00;
                  else         stage_q[g] <= stage_q[g-1];
               end
            end
         end
         assign bck_o = stage_q[STAGES-1][0];
         assign ws_o  = stage_q[STAGES-1][1];
      end
   endgenerate

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
   import aclk_pkg::*;
#(
   parameter int unsigned DIV_W         = 6,
   parameter int unsigned FS_W          = 6,
   parameter int unsigned SLOT_W        = 32,
   parameter int unsigned SLOTS         = 2,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          ODD_HIGH_LONG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             master_i,
   input  logic             mck_drive_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [FS_W-1:0]  fsr_i,
   input  logic             ck_on_i,
   input  logic             ck_off_i,
   input  logic             ext_bck_i,
   input  logic             ext_ws_i,
   output logic             mck_o,
   output logic             mck_tick_o,
   output logic             bck_o,
   output logic             ws_o,
   output logic             frame_tick_o
);

   localparam int unsigned STEP = half_bit_step(SLOTS);

   // elaboration-time parameter checks
   if (DIV_W < 1) begin : g_bad_div
      $error("aclk_gen: DIV_W must be at least 1");
   end
   if ((SLOT_W < 2) || ((SLOT_W % 2) != 0)) begin : g_bad_slot
      $error("aclk_gen: SLOT_W must be even and at least 2");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("aclk_gen: SLOTS must be at least 1");
   end
   if ((STEP - 1) >= (2 ** FS_W)) begin : g_bad_fs
      $error("aclk_gen: FS_W too narrow for the minimum frame ratio");
   end

   logic run, load, frame_last;
   logic mck_lvl, mck_tick;
   logic fr_bck, fr_ws, fr_tick;
   logic sl_bck, sl_ws;
   logic mck_drive_q;

   aclk_run_ctrl u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .master_i     (master_i),
      .on_i         (ck_on_i),
      .off_i        (ck_off_i),
      .frame_last_i (frame_last),
      .run_o        (run),
      .load_o       (load)
   );

   aclk_mck_div #(
      .DIV_W         (DIV_W),
      .ODD_HIGH_LONG (ODD_HIGH_LONG)
   ) u_mck (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .load_i (load),
      .div_i  (div_i),
      .lvl_o  (mck_lvl),
      .tick_o (mck_tick)
   );

   aclk_frame_timer #(
      .FS_W   (FS_W),
      .SLOT_W (SLOT_W),
      .SLOTS  (SLOTS)
   ) u_frame (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .load_i (load),
      .fsr_i  (fsr_i),
      .bck_o  (fr_bck),
      .ws_o   (fr_ws),
      .tick_o (fr_tick),
      .last_o (frame_last)
   );

   aclk_slave_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bck_i  (ext_bck_i),
      .ws_i   (ext_ws_i),
      .bck_o  (sl_bck),
      .ws_o   (sl_ws)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mck_drive_q <= 1'b0;
      else if (load) mck_drive_q <= mck_drive_i;
      else if (!run) mck_drive_q <= 1'b0;
   end

   assign mck_o        = master_i && mck_drive_q && mck_lvl;
   assign mck_tick_o   = master_i && mck_drive_q && mck_tick;
   assign frame_tick_o = master_i && fr_tick;
   assign bck_o        = master_i ? fr_bck : sl_bck;
   assign ws_o         = master_i ? fr_ws  : sl_ws;

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic master_i,
   input logic run,
   input logic mck_drive_q,
   input logic mck_o,
   input logic mck_tick_o,
   input logic bck_o,
   input logic ws_o,
   input logic frame_tick_o
);

   AST_TICK_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mck_tick_o |-> mck_o); // R2

   AST_MCK_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && !mck_drive_q) |-> (!mck_o && !mck_tick_o)); // R3

   AST_FRAME_OPENS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_tick_o |-> (!ws_o && !bck_o)); // R4

   AST_FRAME_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_i && $past(master_i) && frame_tick_o && $past(run)) |-> $past(ws_o)); // R5

   AST_STOP_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_i && $past(master_i) && $fell(run)) |-> $past(ws_o && bck_o)); // R8

   AST_SLAVE_NO_MCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master_i |-> (!mck_o && !mck_tick_o && !frame_tick_o)); // R10

endmodule

bind aclk_gen aclk_gen_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .master_i     (master_i),
   .run          (run),
   .mck_drive_q  (mck_drive_q),
   .mck_o        (mck_o),
   .mck_tick_o   (mck_tick_o),
   .bck_o        (bck_o),
   .ws_o         (ws_o),
   .frame_tick_o (frame_tick_o)
);

// File: tb/aclk_gen_test.sv
`timescale 1ns/1ps
module aclk_gen_test;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master = 1'b0, drive = 1'b0, ck_on = 1'b0, ck_off = 1'b0;
   logic [5:0] div = '0, fs = '0;
   logic       ext_bck = 1'b0, ext_ws = 1'b0;
   logic       mck, mck_tick, bck, ws, ftick;

   always #4 clk = ~clk; // 125 MHz

   aclk_gen uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .master_i     (master),
      .mck_drive_i  (drive),
      .div_i        (div),
      .fsr_i        (fs),
      .ck_on_i      (ck_on),
      .ck_off_i     (ck_off),
      .ext_bck_i    (ext_bck),
      .ext_ws_i     (ext_ws),
      .mck_o        (mck),
      .mck_tick_o   (mck_tick),
      .bck_o        (bck),
      .ws_o         (ws),
      .frame_tick_o (ftick)
   );

   int total = 0, bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int  m_run = 0, m_pend = 0, m_pos = 0, m_c = 0, m_d = 1, m_n = 4, m_drv = 0;
   logic qb[$], qw[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_pend = 0; m_pos = 0; m_c = 0; m_d = 1; m_n = 4; m_drv = 0;
         qb = {}; qw = {};
         for (int i = 0; i < SYNC; i++) begin qb.push_back(1'b0); qw.push_back(1'b0); end
      end else begin
         qb.push_front(ext_bck); void'(qb.pop_back());
         qw.push_front(ext_ws);  void'(qw.pop_back());
         if (!master) begin
            m_run = 0; m_pend = 0;
         end else if (m_run == 0) begin
            if (ck_on && !ck_off) begin
               m_run = 1; m_pend = 0; m_pos = 0; m_c = 0;
               m_d = int'(div) + 1;
               m_n = ((fs < 3) ? 3 : int'(fs)) + 1;
               m_drv = int'(drive);
            end
         end else begin
            int lastc, nxt;
            lastc = (m_pos == 32 * m_n - 1);
            nxt = ck_off ? 1 : (ck_on ? 0 : m_pend);
            if (lastc && nxt) begin
               m_run = 0; m_pend = 0;
            end else begin
               m_pos = lastc ? 0 : m_pos + 1;
               m_c = (m_c == m_d - 1) ? 0 : m_c + 1;
               m_pend = nxt;
            end
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (master) begin
            int e_mck, e_tick, e_bck, e_ws, e_ft;
            e_mck  = (m_run && m_drv && (m_c < (m_d + 1) / 2));
            e_tick = (m_run && m_drv && (m_c == 0));
            e_bck  = (m_run && ((((4 * m_pos) / m_n) % 2) == 1));
            e_ws   = (m_run && (m_pos >= 16 * m_n));
            e_ft   = (m_run && (m_pos == 0));
            chk(m_drv ? "R2 mck level" : "R3 mck muted", int'(mck), e_mck);
            chk(m_drv ? "R2 mck tick" : "R3 tick muted", int'(mck_tick), e_tick);
            chk("R5 bit clock", int'(bck), e_bck);
            chk("R4 frame clock", int'(ws), e_ws);
            chk("R4 frame tick", int'(ftick), e_ft);
         end else begin
            chk("R10 slave bck", int'(bck), int'(qb[SYNC-1]));
            chk("R10 slave ws", int'(ws), int'(qw[SYNC-1]));
            chk("R10 slave mck", int'(mck | mck_tick | ftick), 0);
         end
      end
   end

   // frame length and ratio monitor
   int len_cnt = 0, last_len = 0, tick_cnt = 0, last_ratio = 0, frames = 0;
   always @(negedge clk) begin
      if (ftick) begin
         last_len = len_cnt; len_cnt = 1;
         last_ratio = tick_cnt; tick_cnt = mck_tick ? 1 : 0;
         frames++;
      end else begin
         len_cnt++;
         if (mck_tick) tick_cnt++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cmd(input logic on, input logic off);
      ck_on = on; ck_off = off;
      cyc(1);
      ck_on = 1'b0; ck_off = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      int fr;
      cyc(3);
      chk("R1 reset outputs", int'({mck, mck_tick, bck, ws, ftick}), 0);
      rst_n = 1'b1;
      cyc(5);
      chk("R1 idle after reset", int'({mck, mck_tick, bck, ws, ftick}), 0);

      // 256x ratio
      master = 1'b1; drive = 1'b1; div = 6'd7; fs = 6'd63;
      cmd(1'b1, 1'b0);
      cyc(2048 * 2 + 20);
      chk("R6 ticks per frame 256", last_ratio, 256);
      chk("R4 frame length 2048", last_len, 2048);
      // fields changed while running are ignored
      div = 6'd3; fs = 6'd15;
      cyc(2048 * 2);
      chk("R7 ratio kept after field change", last_ratio, 256);
      chk("R7 length kept after field change", last_len, 2048);
      cmd(1'b0, 1'b1);
      cyc(2100);
      fr = frames;
      cyc(100);
      chk("R8 stopped after frame end", frames, fr);
      chk("R8 outputs low when stopped", int'({mck, bck, ws}), 0);

      // 64x ratio
      div = 6'd7; fs = 6'd15;
      cmd(1'b1, 1'b0);
      cyc(1100);
      chk("R6 ticks per frame 64", last_ratio, 64);
      chk("R4 frame length 512", last_len, 512);
      // stop cancelled by a later on command
      cmd(1'b0, 1'b1);
      cyc(100);
      cmd(1'b1, 1'b0);
      fr = frames;
      cyc(1100);
      chk("R8 cancel keeps running", int'(frames > fr), 1);
      // simultaneous on and off while running acts as off
      cmd(1'b1, 1'b1);
      cyc(600);
      fr = frames;
      cyc(50);
      chk("R8 on+off while running stops", frames, fr);
      // simultaneous while stopped: no start
      cmd(1'b1, 1'b1);
      cyc(50);
      chk("R8 on+off while stopped no start", frames, fr);

      // odd divide, fractional bit clock, master clock not driven
      drive = 1'b0; div = 6'd2; fs = 6'd5;
      cmd(1'b1, 1'b0);
      cyc(500);
      chk("R4 frame length 192", last_len, 192);
      chk("R3 no master ticks", last_ratio, 0);
      cmd(1'b0, 1'b1);
      cyc(300);

      // divide by one and clamped frame ratio
      drive = 1'b1; div = 6'd0; fs = 6'd1;
      cmd(1'b1, 1'b0);
      cyc(600);
      chk("R9 clamped frame length 128", last_len, 128);
      chk("R11 tick every cycle", last_ratio, 128);

      // slave role: immediate stop, forwarding, on ignored
      master = 1'b0;
      cyc(3);
      for (int i = 0; i < 200; i++) begin
         ext_bck = i[0];
         ext_ws  = i[4];
         if (i == 50) ck_on = 1'b1;
         if (i == 51) ck_on = 1'b0;
         cyc(1);
      end
      chk("R10 on ignored in slave role", int'(ftick | mck), 0);
      cyc(5);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         summary();
      end
   end

endmodule